// File: doc/BRIEF.md
# Configurable UART Serial Engine

This block is the serial core of an asynchronous serial port. It turns bytes taken from a transmit queue into framed serial bits on `txd`. It also recovers framed bytes from `rxd` and hands them to a receive queue. The queues themselves sit outside the block.

Bit timing comes from two stages. A prescaler, which can be bypassed, produces a tick once every `cfg_div+1` clocks. A second count then stretches each serial bit to `cfg_tpb+1` ticks. With this split, a wide range of baud rates can be reached from a fixed clock while keeping a fine fractional grid. Each frame has:

- one low start bit;
- eight data bits, least significant first;
- an optional even or odd parity bit;
- one, one and a half, or two high stop bits.

The receiver reports a parity fault or a framing fault with every byte it delivers. It also keeps a sticky error flag that system software clears. All configuration inputs are static and are changed only while the line is idle.

Top module: `uart_serial_engine`

## Requirements
- R1: When `cfg_div_en` is 1, a prescaled tick occurs every `cfg_div+1` clocks. When it is 0, a tick occurs every clock. One serial bit lasts `(cfg_tpb+1)` ticks.
- R2: A `cfg_tpb` value below 3 behaves exactly as the value 3.
- R3: `txd` is high while idle. A transmitted frame consists of a low start bit, eight data bits with bit 0 first, the optional parity bit, and stop time driven high.
- R4: With `cfg_par_en`=1, a parity bit follows the data. When `cfg_par_odd`=0 (even), the parity bit equals the XOR of the eight data bits. When `cfg_par_odd`=1 (odd), it equals the inverse of that XOR. With `cfg_par_en`=0, no parity bit is sent.
- R5: The stop time is set by `cfg_stop_sel`:
  - 2'b00 gives one bit time.
  - 2'b01 gives floor(3*(tpb+1)/2) ticks.
  - 2'b10 or 2'b11 gives two bit times.
- R6: `tx_pop` pulses for one clock only when `tx_valid` is 1 and no frame is in progress. When the queue stays non-empty, the next start bit begins on the clock right after the previous stop time ends. When the queue is empty, `txd` stays high and nothing is popped.
- R7: A received frame produces a one-clock `rx_push` during the first stop bit, with the byte on `rx_data`.
- R8: A falling edge on `rxd` whose line is back high at the middle of the start bit is discarded, and no byte is pushed.
- R9: `rx_par_bad` is 1 with `rx_push` when parity is enabled and the received parity bit differs from the one R4 prescribes.
- R10: `rx_frm_bad` is 1 with `rx_push` when the first stop bit is sampled low.
- R11: `rx_err` rises on the clock after a push that carries either fault. It stays high until `err_clr` is asserted, and a new fault wins over a simultaneous clear.
- R12: After reset, `txd`=1 and `tx_pop`, `rx_push` and `rx_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div_en | input | 1 | Prescaler enable; 0 ticks every clock |
| cfg_div | input | DIV_W | Prescaler divisor minus one |
| cfg_tpb | input | TPB_W | Ticks per bit minus one (3..15) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_stop_sel | input | 2 | Stop length code |
| tx_valid | input | 1 | Transmit queue non-empty |
| tx_data | input | DATA_W | Head of transmit queue |
| tx_pop | output | 1 | Take head of transmit queue |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_push | output | 1 | Received byte valid, one clock |
| rx_data | output | DATA_W | Received byte |
| rx_par_bad | output | 1 | Parity fault of pushed byte |
| rx_frm_bad | output | 1 | Framing fault of pushed byte |
| err_clr | input | 1 | Clear sticky receive error |
| rx_err | output | 1 | Sticky receive error |

## Verification
The bench builds the engine with its default parameters:

- a 16-bit divisor;
- a 4-bit ticks-per-bit field;
- eight data bits;
- a two-flop synchroniser.

The 4-bit field lets a single build cover the whole 3..15 range as well as the clamp of smaller values. The bench uses small divisor values (bypass, 0, 1, 2, 3). This keeps frames short while still exercising the case where the prescaler is enabled with a divide of one, as distinct from bypass. It also exercises odd tick counts, for which the one-and-a-half stop length rounds down. For each frame, the transmit line is sampled at mid-bit and its length is measured to the clock. The receiver is checked in loopback, and with hand-driven frames that carry bad parity, a low stop bit, or a glitch start.

// File: rtl/uart_eng_pkg.sv
package uart_eng_pkg;
   // Position within a serial frame, shared by both directions
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } phase_e;

   // Smallest legal ticks-per-bit field value
   localparam int TPB_FLOOR = 3;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   // Wrap on >= so a smaller divisor written mid-count cannot stall the chain
   assign tick = !en || (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
   import uart_eng_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int TPB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [TPB_W-1:0]  tpb,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [1:0]        stop_sel,
   input  logic              q_valid,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_pop,
   output logic              txd
);
   localparam int CNT_W = TPB_W + 2;
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   phase_e            ph;
   logic [CNT_W-1:0]  tcnt;
   logic [BIT_W-1:0]  bidx;
   logic [DATA_W-1:0] shreg;
   logic              pbit;

   logic [CNT_W-1:0]  bit_len, stop_len, el_len;
   logic              el_done, frame_end, can_load;

   always_comb begin
      bit_len = CNT_W'(tpb) + 1'b1;
      unique case (stop_sel)
         2'b00:   stop_len = bit_len;
         2'b01:   stop_len = bit_len + (bit_len >> 1);
         default: stop_len = bit_len << 1;
      endcase
      el_len = (ph == PH_STOP) ? stop_len : bit_len;
   end

   assign el_done   = tick && (tcnt == el_len - 1'b1);
   assign frame_end = (ph == PH_STOP) && el_done;
   assign can_load  = ((ph == PH_IDLE) && tick) || frame_end;
   assign q_pop     = can_load && q_valid;

   always_comb begin
      unique case (ph)
         PH_START: txd = 1'b0;
         PH_DATA:  txd = shreg[0];
         PH_PAR:   txd = pbit;
         default:  txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         tcnt  <= '0;
         bidx  <= '0;
         shreg <= '0;
         pbit  <= 1'b0;
      end else if (q_pop) begin
         ph    <= PH_START;
         tcnt  <= '0;
         bidx  <= '0;
         shreg <= q_data;
         pbit  <= (^q_data) ^ par_odd;
      end else if (frame_end) begin
         ph   <= PH_IDLE;
         tcnt <= '0;
      end else if (tick && ph != PH_IDLE) begin
         if (el_done) begin
            tcnt <= '0;
            unique case (ph)
               PH_START: ph <= PH_DATA;
               PH_DATA: begin
                  shreg <= shreg >> 1;
                  if (bidx == LAST_BIT) ph <= par_en ? PH_PAR : PH_STOP;
                  else                  bidx <= bidx + 1'b1;
               end
               PH_PAR:  ph <= PH_STOP;
               default: ;
            endcase
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
   import uart_eng_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TPB_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [TPB_W-1:0]  tpb,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rxd,
   output logic              push,
   output logic [DATA_W-1:0] data,
   output logic              par_bad,
   output logic              frm_bad
);
   localparam int CNT_W = TPB_W + 1;
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   logic [SYNC_STAGES-1:0] sync;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync <= '1;
            else        sync <= rxd;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync <= '1;
            else        sync <= {sync[SYNC_STAGES-2:0], rxd};
         end
      end
   endgenerate

   logic rx_s, rx_prev;
   assign rx_s = sync[SYNC_STAGES-1];

   phase_e            ph;
   logic [CNT_W-1:0]  tcnt;
   logic [BIT_W-1:0]  bidx;
   logic [DATA_W-1:0] shreg;
   logic              perr;
   logic [CNT_W-1:0]  bit_len, mid;
   logic              samp, last;

   assign bit_len = CNT_W'(tpb) + 1'b1;
   assign mid     = (bit_len - 1'b1) >> 1;
   assign samp    = tick && (tcnt == mid);
   assign last    = tick && (tcnt == bit_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_prev <= 1'b1;
         ph      <= PH_IDLE;
         tcnt    <= '0;
         bidx    <= '0;
         shreg   <= '0;
         perr    <= 1'b0;
         push    <= 1'b0;
         data    <= '0;
         par_bad <= 1'b0;
         frm_bad <= 1'b0;
      end else begin
         rx_prev <= rx_s;
         push    <= 1'b0;
         if (ph == PH_IDLE) begin
            if (rx_prev && !rx_s) begin
               ph   <= PH_START;
               tcnt <= '0;
               bidx <= '0;
               perr <= 1'b0;
            end
         end else if (tick) begin
            tcnt <= last ? '0 : tcnt + 1'b1;
            unique case (ph)
               PH_START: begin
                  if (samp && rx_s) ph <= PH_IDLE;
                  else if (last)    ph <= PH_DATA;
               end
               PH_DATA: begin
                  if (samp) shreg <= {rx_s, shreg[DATA_W-1:1]};
                  if (last) begin
                     if (bidx == LAST_BIT) ph <= par_en ? PH_PAR : PH_STOP;
                     else                  bidx <= bidx + 1'b1;
                  end
               end
               PH_PAR: begin
                  if (samp) perr <= rx_s ^ (^shreg) ^ par_odd;
                  if (last) ph <= PH_STOP;
               end
               default: begin
                  if (samp) begin
                     push    <= 1'b1;
                     data    <= shreg;
                     par_bad <= perr;
                     frm_bad <= !rx_s;
                     ph      <= PH_IDLE;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_serial_engine.sv
module uart_serial_engine
   import uart_eng_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int TPB_W       = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_div_en,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [TPB_W-1:0]  cfg_tpb,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic [1:0]        cfg_stop_sel,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_pop,
   output logic              txd,
   input  logic              rxd,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_par_bad,
   output logic              rx_frm_bad,
   input  logic              err_clr,
   output logic              rx_err
);
   localparam logic [TPB_W-1:0] TPB_MIN = TPB_W'(TPB_FLOOR);

   generate
      if (TPB_W < 2) begin : g_bad_tpb_w
         $error("TPB_W must hold the minimum ticks-per-bit value");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic             tick;
   logic [TPB_W-1:0] tpb_eff;

   assign tpb_eff = (cfg_tpb < TPB_MIN) ? TPB_MIN : cfg_tpb;

   uart_tick_gen #(.DIV_W(DIV_W)) tick_i (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (cfg_div_en),
      .div  (cfg_div),
      .tick (tick)
   );

   uart_tx_path #(.DATA_W(DATA_W), .TPB_W(TPB_W)) tx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .tpb     (tpb_eff),
      .par_en  (cfg_par_en),
      .par_odd (cfg_par_odd),
      .stop_sel(cfg_stop_sel),
      .q_valid (tx_valid),
      .q_data  (tx_data),
      .q_pop   (tx_pop),
      .txd     (txd)
   );

   uart_rx_path #(.DATA_W(DATA_W), .TPB_W(TPB_W), .SYNC_STAGES(SYNC_STAGES)) rx_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .tpb    (tpb_eff),
      .par_en (cfg_par_en),
      .par_odd(cfg_par_odd),
      .rxd    (rxd),
      .push   (rx_push),
      .data   (rx_data),
      .par_bad(rx_par_bad),
      .frm_bad(rx_frm_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       rx_err <= 1'b0;
      else if (rx_push && (rx_par_bad || rx_frm_bad))   rx_err <= 1'b1;
      else if (err_clr)                                 rx_err <= 1'b0;
   end
endmodule

// File: rtl/uart_serial_engine_chk.sv
module uart_serial_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic cfg_div_en,
   input logic tx_valid,
   input logic tx_pop,
   input logic txd,
   input logic rx_push,
   input logic rx_par_bad,
   input logic rx_frm_bad,
   input logic err_clr,
   input logic rx_err
);
   // R1
   bypass_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_div_en |-> tick);

   // R6
   pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> tx_valid);

   // R6
   pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> !tx_pop);

   // R3
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> !txd);

   // R7
   push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_push);

   // R11
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && (rx_par_bad || rx_frm_bad) |=> rx_err);

   // R11
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err && !err_clr |=> rx_err);
endmodule

bind uart_serial_engine uart_serial_engine_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .cfg_div_en(cfg_div_en),
   .tx_valid  (tx_valid),
   .tx_pop    (tx_pop),
   .txd       (txd),
   .rx_push   (rx_push),
   .rx_par_bad(rx_par_bad),
   .rx_frm_bad(rx_frm_bad),
   .err_clr   (err_clr),
   .rx_err    (rx_err)
);

// File: tb/uart_serial_engine_tb_top.sv
module uart_serial_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_div_en = 1'b0;
   logic [15:0] cfg_div = '0;
   logic [3:0]  cfg_tpb = 4'd7;
   logic        cfg_par_en = 1'b0;
   logic        cfg_par_odd = 1'b0;
   logic [1:0]  cfg_stop_sel = 2'b00;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_pop, txd, rxd, rx_push, rx_par_bad, rx_frm_bad, rx_err;
   logic [7:0]  rx_data;
   logic        err_clr = 1'b0;
   logic        loop = 1'b0;
   logic        rx_drv = 1'b1;

   always #5 clk = ~clk;

   assign rxd = loop ? txd : rx_drv;

   uart_serial_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_div_en(cfg_div_en), .cfg_div(cfg_div),
      .cfg_tpb(cfg_tpb), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop_sel(cfg_stop_sel), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_pop(tx_pop), .txd(txd), .rxd(rxd), .rx_push(rx_push), .rx_data(rx_data),
      .rx_par_bad(rx_par_bad), .rx_frm_bad(rx_frm_bad), .err_clr(err_clr), .rx_err(rx_err)
   );

   int cyc = 0;
   int nchk = 0;
   int nerr = 0;

   // Transmit queue model
   logic [7:0] q [2];
   int pop_n = 0;
   int q_base = 0;
   int q_len = 0;
   assign tx_valid = (pop_n - q_base) < q_len;
   assign tx_data  = tx_valid ? q[pop_n - q_base] : 8'h00;

   // Receive capture
   logic [7:0] cap_d [16];
   logic       cap_p [16];
   logic       cap_f [16];
   int cap_n = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (tx_pop) pop_n <= pop_n + 1;
      if (rx_push) begin
         cap_d[cap_n % 16] <= rx_data;
         cap_p[cap_n % 16] <= rx_par_bad;
         cap_f[cap_n % 16] <= rx_frm_bad;
         cap_n <= cap_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   typedef struct packed {
      logic        den;
      logic [15:0] div;
      logic [3:0]  tpb;
      logic        pen;
      logic        podd;
      logic [1:0]  stop;
      logic [7:0]  d0;
      logic [7:0]  d1;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'd2, 4'd3,  1'b0, 1'b0, 2'b00, 8'hA5, 8'h3C},
      '{1'b0, 16'd0, 4'd15, 1'b1, 1'b0, 2'b01, 8'h81, 8'h7E},
      '{1'b1, 16'd1, 4'd4,  1'b1, 1'b1, 2'b01, 8'h00, 8'hFF},
      '{1'b1, 16'd0, 4'd7,  1'b1, 1'b1, 2'b10, 8'h5A, 8'hC3},
      '{1'b1, 16'd3, 4'd1,  1'b0, 1'b0, 2'b11, 8'h01, 8'h80}
   };

   // Drive one frame on rxd with 8 clocks per bit (bypass, tpb=7)
   task automatic send_rx(input logic [7:0] d, input bit wpar, input bit pval, input bit sval);
      @(negedge clk);
      rx_drv = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_drv = d[i];
         repeat (8) @(negedge clk);
      end
      if (wpar) begin
         rx_drv = pval;
         repeat (8) @(negedge clk);
      end
      rx_drv = sval;
      repeat (8) @(negedge clk);
      rx_drv = 1'b1;
      repeat (16) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin : main
      int c0;
      repeat (3) @(negedge clk);
      // R12 reset values
      chk(txd == 1'b1 && tx_pop == 1'b0 && rx_push == 1'b0 && rx_err == 1'b0,
          "R12 reset state", {txd, tx_pop, rx_push, rx_err}, 4'b1000);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      // R6 empty queue keeps line idle
      chk(txd == 1'b1 && pop_n == 0, "R6 idle without data", pop_n, 0);

      for (int v = 0; v < NV; v++) begin
         int dv, bl, st, bb, ff, p, t0, cb;
         logic [11:0] bits;
         logic [7:0] e;
         vec_t cv;
         cv = VECS[v];
         cfg_div_en = cv.den; cfg_div = cv.div; cfg_tpb = cv.tpb;
         cfg_par_en = cv.pen; cfg_par_odd = cv.podd; cfg_stop_sel = cv.stop;
         dv = cv.den ? int'(cv.div) + 1 : 1;
         bl = (cv.tpb < 3 ? 3 : int'(cv.tpb)) + 1;     // R2 clamp
         st = (cv.stop == 2'b00) ? bl : (cv.stop == 2'b01) ? (3 * bl) / 2 : 2 * bl;
         p  = cv.pen ? 1 : 0;
         bb = bl * dv;
         ff = ((9 + p) * bl + st) * dv;
         repeat (4) @(negedge clk);
         loop = 1'b1;
         cb = cap_n;
         q[0] = cv.d0; q[1] = cv.d1;
         q_base = pop_n;
         q_len = 2;
         while (txd) @(negedge clk);
         t0 = cyc;
         for (int f = 0; f < 2; f++) begin
            e = f ? cv.d1 : cv.d0;
            bits = '0;
            for (int k = 0; k <= 9 + p; k++) begin
               wait_until(t0 + k * bb + bb / 2);
               bits[k] = txd;
            end
            chk(bits[0] == 1'b0 && bits[9 + p] == 1'b1, "R3 start/stop levels", {bits[0], bits[9+p]}, 2'b01);
            chk(bits[8:1] == e, "R1 R2 R3 data at mid-bit", bits[8:1], e);
            if (p == 1)
               chk(bits[9] == ((^e) ^ cv.podd), "R4 parity bit", bits[9], (^e) ^ cv.podd);
            wait_until(t0 + ff - 1);
            chk(txd == 1'b1, "R5 stop held to frame end", txd, 1);
            if (f == 0) begin
               wait_until(t0 + ff);
               chk(txd == 1'b0, "R5 R6 next start right after stop", txd, 0);
            end
            t0 = t0 + ff;
         end
         wait_until(t0 + 2 * bb);
         chk(txd == 1'b1 && (pop_n - q_base) == 2, "R6 no pop once empty", pop_n - q_base, 2);
         chk(cap_n - cb == 2 && cap_d[cb % 16] == cv.d0 && cap_d[(cb + 1) % 16] == cv.d1 &&
             !cap_p[cb % 16] && !cap_f[cb % 16] && !cap_p[(cb + 1) % 16] && !cap_f[(cb + 1) % 16],
             "R7 loopback receive", cap_d[(cb + 1) % 16], cv.d1);
         loop = 1'b0;
         q_len = 0;
      end

      // Directed receive cases: bypass, 8 clocks per bit
      cfg_div_en = 1'b0; cfg_tpb = 4'd7; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
      cfg_stop_sel = 2'b00;
      repeat (20) @(negedge clk);
      chk(rx_err == 1'b0, "R11 no error after clean frames", rx_err, 0);

      c0 = cap_n;
      send_rx(8'h96, 1'b0, 1'b0, 1'b1);
      chk(cap_n - c0 == 1 && cap_d[c0 % 16] == 8'h96 && !cap_p[c0 % 16] && !cap_f[c0 % 16],
          "R7 driven frame", cap_d[c0 % 16], 8'h96);

      // R9 even parity, 0x96 has four ones so the correct bit is 0; send 1
      cfg_par_en = 1'b1;
      c0 = cap_n;
      send_rx(8'h96, 1'b1, 1'b1, 1'b1);
      chk(cap_n - c0 == 1 && cap_p[c0 % 16] && !cap_f[c0 % 16], "R9 parity fault flagged",
          cap_p[c0 % 16], 1);
      chk(rx_err == 1'b1, "R11 error latched", rx_err, 1);

      c0 = cap_n;
      send_rx(8'h96, 1'b1, 1'b0, 1'b1);
      chk(cap_n - c0 == 1 && !cap_p[c0 % 16], "R9 correct parity clean", cap_p[c0 % 16], 0);
      chk(rx_err == 1'b1, "R11 error stays after good frame", rx_err, 1);

      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk(rx_err == 1'b0, "R11 clear", rx_err, 0);

      // R10 stop bit low
      cfg_par_en = 1'b0;
      c0 = cap_n;
      send_rx(8'h3F, 1'b0, 1'b0, 1'b0);
      chk(cap_n - c0 == 1 && cap_f[c0 % 16] && cap_d[c0 % 16] == 8'h3F, "R10 framing fault flagged",
          cap_f[c0 % 16], 1);
      chk(rx_err == 1'b1, "R11 framing sets error", rx_err, 1);

      // R8 glitch start
      c0 = cap_n;
      @(negedge clk); rx_drv = 1'b0;
      repeat (2) @(negedge clk); rx_drv = 1'b1;
      repeat (40) @(negedge clk);
      chk(cap_n == c0, "R8 short low pulse ignored", cap_n - c0, 0);

      // R8 a real frame right after the glitch is still received
      send_rx(8'hC5, 1'b0, 1'b0, 1'b1);
      chk(cap_n - c0 == 1 && cap_d[c0 % 16] == 8'hC5, "R8 recovery after glitch", cap_d[c0 % 16], 8'hC5);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule